// File: doc/BRIEF.md
# Dual Store Queue Burst Writer

This block sits between a processor's store path and an external memory bus. It holds two independent 32-byte write buffers, each made of eight 32-bit slots. The processor fills them with ordinary longword or quadword stores to a reserved address window. A store's address picks the buffer and the slot, and the data lands there directly.

A flush command to the same window names one buffer. The block then sends that buffer's eight slots to memory as one aligned 32-byte burst on a simple valid/ready master port. While one buffer drains, the other still takes stores at full rate. A store that targets the draining buffer is held with a stall until the burst ends. Any flush that arrives during a burst is held the same way, because only one burst runs at a time.

Top module: `dual_sq_burst`

## Requirements
- R1: A store or flush whose address bits [31:26] differ from 6'b111000 changes no slot, starts no burst and raises no stall.
- R2: For a window store, address bit 5 selects the buffer (0 or 1) and bits [4:2] select the slot. A longword store writes st_data[31:0] into that slot.
- R3: A quadword store (st_quad=1) writes st_data[31:0] into the even slot {addr[4:3],0} and st_data[63:32] into the next slot, whatever the value of addr[2].
- R4: An accepted flush drains the buffer named by its address bit 5 as eight beats. Beat k carries slot k, and beats go in ascending slot order.
- R5: Beat k carries the address {upper_q, fl_addr[25:5], 5'b00000} + 4*k, where upper_q is the 6-bit upper-address input of the drained buffer. The first beat is therefore 32-byte aligned.
- R6: A beat advances only on a cycle with m_valid and m_ready both high. While m_ready is low, m_addr and m_data hold. m_last is high on beat 7 only.
- R7: During a burst, a window store to the other buffer is accepted in the same cycle, with st_stall low.
- R8: During a burst, a window store to the draining buffer raises st_stall and writes nothing until the last beat has been accepted.
- R9: A window flush raises fl_stall while any burst is active and is not accepted. With no burst active it is taken at once, with fl_stall low.
- R10: After reset, m_valid is low, both stalls are low, and every slot of both buffers reads 0.
- R11: A store accepted in the same cycle as a flush of its buffer is part of that burst.
- R12: m_valid is high from the cycle after a flush is accepted until the last beat's handshake, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store address |
| st_data | input | 64 | Store data; upper half used by quadword stores |
| st_quad | input | 1 | 1 = quadword store, 0 = longword store |
| st_stall | output | 1 | Store held this cycle |
| fl_valid | input | 1 | Flush request |
| fl_addr | input | 32 | Flush address; selects buffer and destination |
| fl_stall | output | 1 | Flush held this cycle |
| upper0 | input | 6 | Destination upper address bits for buffer 0 |
| upper1 | input | 6 | Destination upper address bits for buffer 1 |
| m_addr | output | 32 | Address of the current beat |
| m_data | output | 32 | Data of the current beat |
| m_valid | output | 1 | Beat valid |
| m_ready | input | 1 | Memory accepts the beat |
| m_last | output | 1 | Final beat of the burst |

## Verification
On every cycle, the assertions check that a held beat keeps its address and data, that a burst starts on a 32-byte boundary, that m_valid falls after the last handshake, and that no slot of the draining buffer is written. Slot placement for longword and quadword stores, buffer and slot decode, and window filtering can only be shown by the bench. It compares every drained beat with its own model of both buffers. The same holds for same-cycle store-and-flush ordering and for stores to the idle buffer being taken while the other one drains under random ready stalls.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int SLOTS   = 8;
    localparam int QUEUES  = 2;
    localparam int HI_W    = 6;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int LINE_LSB = SLOT_W + 2;                 // 5
    localparam int MID_W   = ADDR_W - HI_W - LINE_LSB;    // 21
    localparam logic [HI_W-1:0] WIN_TAG = 6'b111000;

    typedef struct packed {
        logic              hit;
        logic              q;
        logic [SLOT_W-1:0] slot;
    } sq_dec_t;

    typedef struct packed {
        logic              en;
        logic              q;
        logic              quad;
        logic [SLOT_W-1:0] slot;
        logic [2*WORD_W-1:0] data;
    } sq_wr_t;

    function automatic sq_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        sq_dec_t d;
        d.hit  = (a[ADDR_W-1 -: HI_W] == WIN_TAG);
        d.q    = a[LINE_LSB];
        d.slot = a[LINE_LSB-1:2];
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] line_base(input logic [HI_W-1:0] hi,
                                                   input logic [ADDR_W-1:0] a);
        return {hi, a[LINE_LSB+MID_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/sq_decode.sv
module sq_decode
    import sqb_pkg::*;
(
    input  logic                st_valid,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [2*WORD_W-1:0] st_data,
    input  logic                st_quad,
    input  logic                fl_valid,
    input  logic [ADDR_W-1:0]   fl_addr,
    input  logic [HI_W-1:0]     upper0,
    input  logic [HI_W-1:0]     upper1,
    input  logic                busy,
    input  logic                act_q,
    output logic                st_stall,
    output logic                fl_stall,
    output sq_wr_t              wr,
    output logic                fl_go,
    output logic                fl_q,
    output logic [ADDR_W-1:0]   fl_base
);
    sq_dec_t sd, fd;

    always_comb begin
        sd = decode_addr(st_addr);
        fd = decode_addr(fl_addr);

        st_stall = st_valid && sd.hit && busy && (sd.q == act_q);
        fl_stall = fl_valid && fd.hit && busy;

        wr.en   = st_valid && sd.hit && !st_stall;
        wr.q    = sd.q;
        wr.quad = st_quad;
        wr.slot = sd.slot;
        wr.data = st_data;

        fl_go   = fl_valid && fd.hit && !busy;
        fl_q    = fd.q;
        fl_base = line_base(fd.q ? upper1 : upper0, fl_addr);
    end
endmodule

// File: rtl/sq_bank.sv
module sq_bank
    import sqb_pkg::*;
#(
    parameter logic QID = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  sq_wr_t            wr,
    input  logic              blocked,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [SLOTS];
    logic              mine;
    logic [SLOT_W-1:0] lo_slot;

    always_comb begin
        mine    = wr.en && (wr.q == QID);
        lo_slot = wr.quad ? {wr.slot[SLOT_W-1:1], 1'b0} : wr.slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else if (mine) begin
            mem[lo_slot] <= wr.data[WORD_W-1:0];
            if (wr.quad) mem[lo_slot | 1] <= wr.data[2*WORD_W-1:WORD_W];
        end
    end

    assign rd_data = mem[rd_slot];

    // No write may land in a buffer that is being drained.
    assert_no_write_draining_R8: assert property (@(posedge clk) disable iff (rst)
        mine |-> !blocked);
endmodule

// File: rtl/sq_drain.sv
module sq_drain
    import sqb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_q,
    input  logic [ADDR_W-1:0] go_base,
    input  logic              m_ready,
    output logic              busy,
    output logic              act_q,
    output logic [SLOT_W-1:0] beat,
    output logic              m_valid,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_last
);
    logic [ADDR_W-1:0] base_q;
    logic              fire;

    always_comb begin
        fire    = busy && m_ready;
        m_valid = busy;
        m_last  = busy && (beat == SLOT_W'(SLOTS-1));
        m_addr  = base_q | {{(ADDR_W-SLOT_W-2){1'b0}}, beat, 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            act_q  <= 1'b0;
            beat   <= '0;
            base_q <= '0;
        end else if (!busy) begin
            if (go) begin
                busy   <= 1'b1;
                act_q  <= go_q;
                beat   <= '0;
                base_q <= go_base;
            end
        end else if (fire) begin
            if (m_last) busy <= 1'b0;
            beat <= beat + 1'b1;
        end
    end

    assert_hold_when_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr)));
    assert_aligned_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(m_valid) |-> (m_addr[LINE_LSB-1:0] == '0));
    assert_drop_after_last_R12: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> !m_valid);
    assert_step_by_word_R4: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && !m_last) |=> (m_valid && m_addr == $past(m_addr) + 4));
endmodule

// File: rtl/dual_sq_burst.sv
module dual_sq_burst
    import sqb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                st_valid,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [2*WORD_W-1:0] st_data,
    input  logic                st_quad,
    output logic                st_stall,
    input  logic                fl_valid,
    input  logic [ADDR_W-1:0]   fl_addr,
    output logic                fl_stall,
    input  logic [HI_W-1:0]     upper0,
    input  logic [HI_W-1:0]     upper1,
    output logic [ADDR_W-1:0]   m_addr,
    output logic [WORD_W-1:0]   m_data,
    output logic                m_valid,
    input  logic                m_ready,
    output logic                m_last
);
    sq_wr_t            wr;
    logic              fl_go, fl_q, busy, act_q;
    logic [ADDR_W-1:0] fl_base;
    logic [SLOT_W-1:0] beat;
    logic [WORD_W-1:0] rd [QUEUES];

    sq_decode u_dec (
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_quad(st_quad),
        .fl_valid(fl_valid), .fl_addr(fl_addr), .upper0(upper0), .upper1(upper1),
        .busy(busy), .act_q(act_q), .st_stall(st_stall), .fl_stall(fl_stall),
        .wr(wr), .fl_go(fl_go), .fl_q(fl_q), .fl_base(fl_base)
    );

    for (genvar g = 0; g < QUEUES; g++) begin : g_bank
        sq_bank #(.QID(1'(g))) u_bank (
            .clk(clk), .rst(rst), .wr(wr),
            .blocked(busy && (act_q == 1'(g))),
            .rd_slot(beat), .rd_data(rd[g])
        );
    end

    sq_drain u_drain (
        .clk(clk), .rst(rst), .go(fl_go), .go_q(fl_q), .go_base(fl_base),
        .m_ready(m_ready), .busy(busy), .act_q(act_q), .beat(beat),
        .m_valid(m_valid), .m_addr(m_addr), .m_last(m_last)
    );

    assign m_data = rd[act_q];

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> $stable(m_data));
    assert_no_stall_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !m_valid |-> (!st_stall && !fl_stall));
endmodule

// File: tb/dual_sq_burst_tb.sv
module dual_sq_burst_tb;
    logic        clk = 0, rst = 1;
    logic        st_valid = 0, st_quad = 0, fl_valid = 0, m_ready = 0;
    logic [31:0] st_addr = 0, fl_addr = 0;
    logic [63:0] st_data = 0;
    logic [5:0]  upper0 = 6'h15, upper1 = 6'h2a;
    logic        st_stall, fl_stall, m_valid, m_last;
    logic [31:0] m_addr, m_data;

    int checks = 0, fails = 0;
    logic [31:0] model [2][8];

    always #2 clk = ~clk;

    dual_sq_burst u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_quad(st_quad), .st_stall(st_stall), .fl_valid(fl_valid), .fl_addr(fl_addr),
        .fl_stall(fl_stall), .upper0(upper0), .upper1(upper1), .m_addr(m_addr),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [31:0] a);
        return a[31:26] == 6'b111000;
    endfunction

    function automatic logic [31:0] win_addr(input logic q, input int slot);
        return {6'b111000, 20'($urandom), q, 3'(slot), 2'b00};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] fa, input int k);
        return {(fa[5] ? upper1 : upper0), fa[25:5], 5'b0} + 32'(4 * k);
    endfunction

    task automatic apply(input logic [31:0] a, input logic [63:0] d, input logic quad);
        int s;
        if (!in_win(a)) return;
        s = int'(a[4:2]);
        if (quad) begin
            s = s & 6;
            model[a[5]][s]     = d[31:0];
            model[a[5]][s + 1] = d[63:32];
        end else model[a[5]][s] = d[31:0];
    endtask

    task automatic store(input logic [31:0] a, input logic [63:0] d, input logic quad);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d; st_quad = quad;
        #1 chk(st_stall == 0, in_win(a) ? "R2 store idle no stall" : "R1 outside no stall", st_stall, 0);
        @(posedge clk);
        apply(a, d, quad);
        @(negedge clk);
        st_valid = 0;
    endtask

    // mode 0: quiet burst; mode 1: random interference. pre: store in flush cycle (R11).
    task automatic flush(input logic [31:0] fa, input int mode, input logic pre,
                         input logic [31:0] pa, input logic [63:0] pd);
        logic q;
        int k, r;
        logic [31:0] ia;
        logic [63:0] id;
        logic iq;
        q = fa[5];
        @(negedge clk);
        fl_valid = 1; fl_addr = fa;
        if (pre) begin st_valid = 1; st_addr = pa; st_data = pd; st_quad = 0; end
        #1 chk(fl_stall == 0, "R9 idle flush taken", fl_stall, 0);
        @(posedge clk);
        if (pre) apply(pa, pd, 0);
        k = 0;
        while (k < 8) begin
            @(negedge clk);
            fl_valid = 0; st_valid = 0;
            m_ready = ($urandom % 4) != 0;
            r = (mode == 1) ? int'($urandom % 4) : 0;
            iq = $urandom % 2;
            id = {$urandom, $urandom};
            if (r == 1) begin ia = win_addr(!q, $urandom % 8); st_valid = 1; st_addr = ia; st_data = id; st_quad = iq; end
            if (r == 2) begin ia = win_addr(q, $urandom % 8);  st_valid = 1; st_addr = ia; st_data = id; st_quad = iq; end
            if (r == 3) begin fl_valid = 1; fl_addr = win_addr($urandom % 2, 0); end
            #1;
            chk(m_valid == 1, "R12 valid during burst", m_valid, 1);
            chk(m_addr == exp_addr(fa, k), "R5 beat address", m_addr, exp_addr(fa, k));
            chk(m_data == model[q][k], "R4 beat data", m_data, model[q][k]);
            chk(m_last == (k == 7), "R6 last marker", m_last, k == 7);
            if (r == 1) chk(st_stall == 0, "R7 other queue no stall", st_stall, 0);
            if (r == 2) chk(st_stall == 1, "R8 draining queue stalls", st_stall, 1);
            if (r == 3) chk(fl_stall == 1, "R9 flush stalls in burst", fl_stall, 1);
            @(posedge clk);
            if (r == 1) apply(ia, id, iq);
            if (m_ready) k++;
        end
        @(negedge clk);
        fl_valid = 0; st_valid = 0; m_ready = 0;
        #1 chk(m_valid == 0, "R12 valid drops after last", m_valid, 0);
    endtask

    initial begin
        int guard = 0;
        while (guard < 150000) begin @(posedge clk); guard++; end
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd1234));
        for (int q = 0; q < 2; q++) for (int s = 0; s < 8; s++) model[q][s] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(m_valid == 0, "R10 reset no valid", m_valid, 0);
        chk(st_stall == 0 && fl_stall == 0, "R10 reset no stall", {st_stall, fl_stall}, 0);
        flush(win_addr(0, 0), 0, 0, 0, 0);    // R10 zeros
        flush(win_addr(1, 0), 0, 0, 0, 0);

        // R2 longwords everywhere
        for (int q = 0; q < 2; q++) for (int s = 0; s < 8; s++)
            store(win_addr(q[0], s), {32'hdead0000, 32'(q * 16 + s + 32'h100)}, 0);
        // R3 quadword at odd slot address goes to even pair
        store(win_addr(1, 5), 64'h1111_2222_3333_4444, 1);
        store(win_addr(0, 2), 64'haaaa_bbbb_cccc_dddd, 1);
        // R1 outside window
        store({6'b111001, 20'h0, 1'b0, 3'd1, 2'b00}, 64'hffff_ffff_ffff_ffff, 0);
        store({6'b011000, 20'h0, 1'b1, 3'd4, 2'b00}, 64'hffff_ffff_ffff_ffff, 1);
        @(negedge clk); fl_valid = 1; fl_addr = 32'h2000_0000;
        #1 chk(fl_stall == 0, "R1 outside flush no stall", fl_stall, 0);
        @(negedge clk); fl_valid = 0;
        #1 chk(m_valid == 0, "R1 outside flush no burst", m_valid, 0);
        flush(win_addr(1, 0), 0, 0, 0, 0);
        flush(win_addr(0, 0), 1, 0, 0, 0);
        // R11 same-cycle store lands in burst
        flush(win_addr(1, 0), 0, 1, win_addr(1, 6), 64'h0000_0000_5eed_cafe);
        flush(win_addr(0, 0), 0, 1, win_addr(0, 0), 64'h0000_0000_0bad_f00d);

        for (int it = 0; it < 60; it++) begin
            if ($urandom % 3 == 0) begin
                upper0 = 6'($urandom); upper1 = 6'($urandom);
                flush(win_addr($urandom % 2, 0), 1, $urandom % 2, win_addr($urandom % 2, $urandom % 8), {$urandom, $urandom});
            end else begin
                a = ($urandom % 5 == 0) ? {$urandom} & 32'hdfff_ffff : win_addr($urandom % 2, $urandom % 8);
                store(a, {$urandom, $urandom}, $urandom % 2);
            end
        end
        flush(win_addr(0, 0), 1, 0, 0, 0);
        flush(win_addr(1, 0), 1, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule